// File: doc/BRIEF.md
# Lane Configuration Register Target with Strap Override

This block is the control-register slave of a four-lane high-speed signal conditioner. A host reaches it over a two-wire I2C bus, which a fast system clock oversamples. The block holds the per-lane settings: equalizer boost, output swing, de-emphasis, lane enable, activity-detector threshold, detector power-down, activity-detector disable and receiver reset. It drives each setting onto a per-lane output bus.

Every transfer starts at register 0 and moves through the registers one byte at a time. There is no offset pointer. Hosts that insist on sending an offset byte still work, because that byte lands on the read-only status register and changes nothing. On the first clock after reset the enable, boost, swing and de-emphasis registers take their values from board strap pins. A mode pin then picks the source of the boost, swing and de-emphasis outputs: the strap pins when it is high, the registers when it is low.

Top module: `lane_cfg_i2c_target`

## Requirements
- R1: The block acknowledges only the 7-bit address {1,1,A4,0,0,A1,A0} (MSB first), where A4 = addr_pins[2], A1 = addr_pins[1] and A0 = addr_pins[0]. For any other address, SDA stays released for that byte and for the rest of the transfer, and no register changes.
- R2: After reset, register 2 reads {4{pwr_en_pin}},0000. Registers 3 and 4 hold boost_pins in both nibbles. Register 5 bits 7,5,3,1 equal swing_pin and bits 6,4,2,0 read 1. Register 6 holds deemph_pins in each 2-bit field. Register 8 reads 0xF0 and registers 9 and A read 0x00.
- R3: A write that follows the address byte goes to register 0, and the pointer moves up by one after each byte. Every data byte is acknowledged. A STOP or a repeated START returns the pointer to register 0.
- R4: A read starts at register 0 and moves up by one for each byte. A master NACK ends the read, and SDA is released.
- R5: Register 0 reads {activity_in[3:0],0000}. Register 1 reads 0x00. Writes to either register, including a leading offset byte, have no effect.
- R6: Reserved registers 7 and B–F read 0x00, and writes to them are ignored. The low nibbles of registers 2 and 9 read 0.
- R7: The low bit of each swing pair (register 5 bits 6,4,2,0) always reads 1 and is always driven as 1 on lane_swing. Writes cannot clear it.
- R8: When strap_mode is high, lane_boost, lane_swing and lane_deemph follow the strap pins for every lane, one clock later. When it is low, they show the registers. The registers keep their contents in both modes.
- R9: lane_en, lane_thresh, lane_det_pd, lane_rx_reset and lane_act_dis always come from the registers, whatever the level of strap_mode.
- R10: Field layout (lane i occupies slice i of each output bus):
  - Register 3: lane 0 in bits 3:0, lane 1 in bits 7:4.
  - Register 4: lane 2 in bits 3:0, lane 3 in bits 7:4.
  - Registers 6 and A: lane i in bits 2i+1:2i.
  - Register 8: detect power-down of lane i in bit 4+i, reset of lane i in bit i.
  - Registers 2 and 9: lane i in bit 4+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND value) |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pins | input | 3 | Address straps {A4,A1,A0} |
| strap_mode | input | 1 | 1: boost, swing and de-emphasis outputs follow the straps |
| boost_pins | input | 4 | Equalizer boost strap |
| swing_pin | input | 1 | Swing strap (high bit of each pair) |
| deemph_pins | input | 2 | De-emphasis strap |
| pwr_en_pin | input | 1 | Lane-enable strap |
| activity_in | input | 4 | Per-lane activity status |
| lane_en | output | 4 | Lane enables |
| lane_boost | output | 16 | 4-bit boost code per lane |
| lane_swing | output | 8 | 2-bit swing pair per lane |
| lane_deemph | output | 8 | 2-bit de-emphasis code per lane |
| lane_thresh | output | 8 | 2-bit detector threshold per lane |
| lane_rx_reset | output | 4 | Per-lane receiver reset |
| lane_det_pd | output | 4 | Per-lane detect power-down |
| lane_act_dis | output | 4 | Per-lane activity-detector disable |

## Verification
The assertions rely on four assumptions about the inputs:
- SDA changes only while SCL is low, except for START and STOP.
- Each SCL level lasts longer than the synchronizer delay plus one clock.
- The strap pins are stable across the reset release.
- The mode pin changes only when no read is in progress.

The bench keeps to these: its master holds each quarter bit for eight system clocks, changes data only a full quarter after SCL falls, and sets every strap before it releases reset.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
  localparam int LANES   = 4;
  localparam int BOOST_W = 4;
  localparam int DE_W    = 2;
  localparam int TH_W    = 2;
  localparam int REG_CNT = 16;
  localparam int PTR_W   = $clog2(REG_CNT);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_MACK
  } xfer_st_t;

  localparam logic [PTR_W-1:0] R_STATUS = 4'h0;
  localparam logic [PTR_W-1:0] R_EN     = 4'h2;
  localparam logic [PTR_W-1:0] R_BST_LO = 4'h3;
  localparam logic [PTR_W-1:0] R_BST_HI = 4'h4;
  localparam logic [PTR_W-1:0] R_SWING  = 4'h5;
  localparam logic [PTR_W-1:0] R_DEEMPH = 4'h6;
  localparam logic [PTR_W-1:0] R_DETCTL = 4'h8;
  localparam logic [PTR_W-1:0] R_ACTDIS = 4'h9;
  localparam logic [PTR_W-1:0] R_THRESH = 4'hA;

  // device address built from the three address straps {A4,A1,A0}
  function automatic logic [6:0] dev_addr(input logic [2:0] pins);
    return {2'b11, pins[2], 2'b00, pins[1:0]};
  endfunction

  // swing register image: high bit per lane from storage, low bit tied to 1
  function automatic logic [2*LANES-1:0] swing_image(input logic [LANES-1:0] hi);
    logic [2*LANES-1:0] b;
    for (int i = 0; i < LANES; i++) b[2*i +: 2] = {hi[i], 1'b1};
    return b;
  endfunction
endpackage

// File: rtl/lcfg_bus_sync.sv
module lcfg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/lcfg_i2c_engine.sv
module lcfg_i2c_engine
  import lcfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [6:0]       my_addr,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] ptr
);
  xfer_st_t   state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] txreg;
  logic       is_read;
  logic       byte_done;

  assign byte_done = (bit_cnt == 4'd8);
  assign wr_en     = (state == ST_WR) && scl_fall && byte_done;
  assign wr_data   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      txreg   <= '0;
      is_read <= 1'b0;
      sda_oe  <= 1'b0;
      ptr     <= '0;
    end else if (start_det) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && byte_done) begin
            if (shreg[7:1] == my_addr) begin
              sda_oe  <= 1'b1;
              is_read <= shreg[0];
              state   <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (is_read) begin
              txreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              ptr    <= ptr + 1'b1;
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && byte_done) begin
            sda_oe <= 1'b1;
            ptr    <= ptr + 1'b1;
            state  <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (byte_done) begin
              sda_oe <= 1'b0;
              state  <= ST_MACK;
            end else begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_s) begin
            state <= ST_IDLE;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            txreg   <= rd_data;
            sda_oe  <= ~rd_data[7];
            ptr     <= ptr + 1'b1;
            state   <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: an idle target never pulls the data line
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R3: a STOP always returns the byte pointer to register 0
  a_r3_ptr_home_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> (ptr == '0));

  // R4: master NACK leaves the line released
  a_r4_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MACK && scl_rise && sda_s && !stop_det && !start_det) |=> (!sda_oe && state == ST_IDLE));

  // R5: write strobes only arise inside a write data phase
  a_r5_write_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (is_read == 1'b0));
endmodule

// File: rtl/lcfg_regfile.sv
module lcfg_regfile
  import lcfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BOOST_W-1:0]       boost_pins,
  input  logic                     swing_pin,
  input  logic [DE_W-1:0]          deemph_pins,
  input  logic                     pwr_en_pin,
  input  logic [LANES-1:0]         activity_in,
  input  logic                     wr_en,
  input  logic [PTR_W-1:0]         addr,
  input  logic [7:0]               wr_data,
  output logic [7:0]               rd_data,
  output logic [LANES-1:0]         en_q,
  output logic [LANES*BOOST_W-1:0] boost_q,
  output logic [LANES-1:0]         swing_hi_q,
  output logic [LANES*DE_W-1:0]    deemph_q,
  output logic [LANES-1:0]         det_pd_q,
  output logic [LANES-1:0]         rx_rst_q,
  output logic [LANES-1:0]         act_dis_q,
  output logic [LANES*TH_W-1:0]    thresh_q
);
  localparam int HALF_B = 2 * BOOST_W;

  logic             strap_pend;
  logic [LANES-1:0] act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_pend <= 1'b1;
      act_q      <= '0;
      en_q       <= '0;
      boost_q    <= '0;
      swing_hi_q <= '0;
      deemph_q   <= '0;
      det_pd_q   <= '1;
      rx_rst_q   <= '0;
      act_dis_q  <= '0;
      thresh_q   <= '0;
    end else begin
      act_q <= activity_in;
      if (strap_pend) begin
        strap_pend <= 1'b0;
        en_q       <= {LANES{pwr_en_pin}};
        boost_q    <= {LANES{boost_pins}};
        swing_hi_q <= {LANES{swing_pin}};
        deemph_q   <= {LANES{deemph_pins}};
      end else if (wr_en) begin
        case (addr)
          R_EN:     en_q <= wr_data[7:4];
          R_BST_LO: boost_q[HALF_B-1:0] <= wr_data;
          R_BST_HI: boost_q[2*HALF_B-1:HALF_B] <= wr_data;
          R_SWING:  for (int i = 0; i < LANES; i++) swing_hi_q[i] <= wr_data[2*i+1];
          R_DEEMPH: deemph_q <= wr_data;
          R_DETCTL: {det_pd_q, rx_rst_q} <= wr_data;
          R_ACTDIS: act_dis_q <= wr_data[7:4];
          R_THRESH: thresh_q <= wr_data;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      R_STATUS: rd_data = {act_q, 4'h0};
      R_EN:     rd_data = {en_q, 4'h0};
      R_BST_LO: rd_data = boost_q[HALF_B-1:0];
      R_BST_HI: rd_data = boost_q[2*HALF_B-1:HALF_B];
      R_SWING:  rd_data = swing_image(swing_hi_q);
      R_DEEMPH: rd_data = deemph_q;
      R_DETCTL: rd_data = {det_pd_q, rx_rst_q};
      R_ACTDIS: rd_data = {act_dis_q, 4'h0};
      R_THRESH: rd_data = thresh_q;
      default:  rd_data = 8'h00;
    endcase
  end

  // R2: the strap capture loads the enables from the power-enable pin
  a_r2_strap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strap_pend) |-> (en_q == {LANES{$past(pwr_en_pin)}}));

  // R6: without a write strobe the stored settings hold
  a_r6_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && !$past(strap_pend)) |->
      $stable({en_q, boost_q, swing_hi_q, deemph_q, det_pd_q, rx_rst_q, act_dis_q, thresh_q}));

  // R5: a write aimed at a read-only or reserved slot changes nothing
  a_r5_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && ($past(addr) < R_EN || $past(addr) == 4'h7 || $past(addr) > R_THRESH)) |->
      $stable({en_q, boost_q, swing_hi_q, deemph_q, det_pd_q, rx_rst_q, act_dis_q, thresh_q}));
endmodule

// File: rtl/lcfg_lane_out.sv
module lcfg_lane_out
  import lcfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strap_mode,
  input  logic [BOOST_W-1:0]       boost_pins,
  input  logic                     swing_pin,
  input  logic [DE_W-1:0]          deemph_pins,
  input  logic [LANES-1:0]         en_q,
  input  logic [LANES*BOOST_W-1:0] boost_q,
  input  logic [LANES-1:0]         swing_hi_q,
  input  logic [LANES*DE_W-1:0]    deemph_q,
  input  logic [LANES-1:0]         det_pd_q,
  input  logic [LANES-1:0]         rx_rst_q,
  input  logic [LANES-1:0]         act_dis_q,
  input  logic [LANES*TH_W-1:0]    thresh_q,
  output logic [LANES-1:0]         lane_en,
  output logic [LANES*BOOST_W-1:0] lane_boost,
  output logic [2*LANES-1:0]       lane_swing,
  output logic [LANES*DE_W-1:0]    lane_deemph,
  output logic [LANES*TH_W-1:0]    lane_thresh,
  output logic [LANES-1:0]         lane_rx_reset,
  output logic [LANES-1:0]         lane_det_pd,
  output logic [LANES-1:0]         lane_act_dis
);
  logic [LANES*BOOST_W-1:0] boost_nx;
  logic [2*LANES-1:0]       swing_nx;
  logic [LANES*DE_W-1:0]    deemph_nx;
  logic                     chk_armed;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign boost_nx[g*BOOST_W +: BOOST_W] = strap_mode ? boost_pins  : boost_q[g*BOOST_W +: BOOST_W];
    assign deemph_nx[g*DE_W +: DE_W]      = strap_mode ? deemph_pins : deemph_q[g*DE_W +: DE_W];
    assign swing_nx[2*g +: 2]             = {(strap_mode ? swing_pin : swing_hi_q[g]), 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_armed     <= 1'b0;
      lane_en       <= '0;
      lane_boost    <= '0;
      lane_swing    <= '0;
      lane_deemph   <= '0;
      lane_thresh   <= '0;
      lane_rx_reset <= '0;
      lane_det_pd   <= '0;
      lane_act_dis  <= '0;
    end else begin
      chk_armed     <= 1'b1;
      lane_en       <= en_q;
      lane_boost    <= boost_nx;
      lane_swing    <= swing_nx;
      lane_deemph   <= deemph_nx;
      lane_thresh   <= thresh_q;
      lane_rx_reset <= rx_rst_q;
      lane_det_pd   <= det_pd_q;
      lane_act_dis  <= act_dis_q;
    end
  end

  // R8: with the mode pin high every lane shows the strap boost a cycle later
  a_r8_strap_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(strap_mode)) |-> (lane_boost == {LANES{$past(boost_pins)}}
                                         && lane_deemph == {LANES{$past(deemph_pins)}}));

  // R9: enables track the register side whatever the mode
  a_r9_enable_from_regs: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed |-> (lane_en == $past(en_q) && lane_thresh == $past(thresh_q)));
endmodule

// File: rtl/lane_cfg_i2c_target.sv
module lane_cfg_i2c_target
  import lcfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_oe,
  input  logic [2:0]               addr_pins,
  input  logic                     strap_mode,
  input  logic [BOOST_W-1:0]       boost_pins,
  input  logic                     swing_pin,
  input  logic [DE_W-1:0]          deemph_pins,
  input  logic                     pwr_en_pin,
  input  logic [LANES-1:0]         activity_in,
  output logic [LANES-1:0]         lane_en,
  output logic [LANES*BOOST_W-1:0] lane_boost,
  output logic [2*LANES-1:0]       lane_swing,
  output logic [LANES*DE_W-1:0]    lane_deemph,
  output logic [LANES*TH_W-1:0]    lane_thresh,
  output logic [LANES-1:0]         lane_rx_reset,
  output logic [LANES-1:0]         lane_det_pd,
  output logic [LANES-1:0]         lane_act_dis
);
  logic                     sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                     wr_en;
  logic [7:0]               wr_data, rd_data;
  logic [PTR_W-1:0]         ptr;
  logic [LANES-1:0]         en_q, swing_hi_q, det_pd_q, rx_rst_q, act_dis_q;
  logic [LANES*BOOST_W-1:0] boost_q;
  logic [LANES*DE_W-1:0]    deemph_q;
  logic [LANES*TH_W-1:0]    thresh_q;

  lcfg_bus_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  lcfg_i2c_engine u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .my_addr(dev_addr(addr_pins)), .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr)
  );

  lcfg_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .boost_pins(boost_pins), .swing_pin(swing_pin),
    .deemph_pins(deemph_pins), .pwr_en_pin(pwr_en_pin), .activity_in(activity_in),
    .wr_en(wr_en), .addr(ptr), .wr_data(wr_data), .rd_data(rd_data),
    .en_q(en_q), .boost_q(boost_q), .swing_hi_q(swing_hi_q), .deemph_q(deemph_q),
    .det_pd_q(det_pd_q), .rx_rst_q(rx_rst_q), .act_dis_q(act_dis_q), .thresh_q(thresh_q)
  );

  lcfg_lane_out u_out (
    .clk(clk), .rst_n(rst_n), .strap_mode(strap_mode), .boost_pins(boost_pins),
    .swing_pin(swing_pin), .deemph_pins(deemph_pins), .en_q(en_q), .boost_q(boost_q),
    .swing_hi_q(swing_hi_q), .deemph_q(deemph_q), .det_pd_q(det_pd_q),
    .rx_rst_q(rx_rst_q), .act_dis_q(act_dis_q), .thresh_q(thresh_q),
    .lane_en(lane_en), .lane_boost(lane_boost), .lane_swing(lane_swing),
    .lane_deemph(lane_deemph), .lane_thresh(lane_thresh), .lane_rx_reset(lane_rx_reset),
    .lane_det_pd(lane_det_pd), .lane_act_dis(lane_act_dis)
  );
endmodule

// File: tb/tb_lane_cfg_i2c_target.sv
`timescale 1ns/1ps
module tb_lane_cfg_i2c_target;
  localparam int QTR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        sda_bus;
  logic        sda_oe;
  logic [2:0]  addr_pins = 3'b101;
  logic        strap_mode = 1'b0;
  logic [3:0]  boost_pins = 4'b1010;
  logic        swing_pin = 1'b1;
  logic [1:0]  deemph_pins = 2'b01;
  logic        pwr_en_pin = 1'b1;
  logic [3:0]  activity_in = 4'b0101;
  logic [3:0]  lane_en, lane_rx_reset, lane_det_pd, lane_act_dis;
  logic [15:0] lane_boost;
  logic [7:0]  lane_swing, lane_deemph, lane_thresh;

  int tests_run = 0;
  int tests_failed = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_q[$];
  logic [7:0] img[16];

  localparam logic [7:0] ADDR_W = 8'hE2;
  localparam logic [7:0] ADDR_R = 8'hE3;
  localparam logic [7:0] BAD_W  = 8'hE4;

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  lane_cfg_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .addr_pins(addr_pins), .strap_mode(strap_mode), .boost_pins(boost_pins),
    .swing_pin(swing_pin), .deemph_pins(deemph_pins), .pwr_en_pin(pwr_en_pin),
    .activity_in(activity_in), .lane_en(lane_en), .lane_boost(lane_boost),
    .lane_swing(lane_swing), .lane_deemph(lane_deemph), .lane_thresh(lane_thresh),
    .lane_rx_reset(lane_rx_reset), .lane_det_pd(lane_det_pd), .lane_act_dis(lane_act_dis)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pairs each byte the master receives with the queued expectation
  always @(negedge clk) begin
    if (got_q.size() != 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {24'h0, g}, {24'h0, e});
      end else begin
        chk("R4 unexpected byte", {24'h0, g}, 32'hFFFF_FFFF);
      end
    end
  end

  task automatic q_wait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; q_wait(); m_scl = 1'b1; q_wait();
    m_sda = 1'b0; q_wait(); m_scl = 1'b0; q_wait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; q_wait(); m_scl = 1'b1; q_wait(); m_sda = 1'b1; q_wait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; q_wait(); m_scl = 1'b1; q_wait(); q_wait(); m_scl = 1'b0; q_wait();
    end
    m_sda = 1'b1; q_wait(); m_scl = 1'b1; q_wait();
    acked = ~sda_bus;
    q_wait(); m_scl = 1'b0; q_wait();
  endtask

  task automatic recv_byte(input logic give_ack);
    logic [7:0] v;
    v = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      q_wait(); m_scl = 1'b1; q_wait();
      v = {v[6:0], sda_bus};
      q_wait(); m_scl = 1'b0;
    end
    q_wait();
    m_sda = ~give_ack; q_wait(); m_scl = 1'b1; q_wait(); q_wait(); m_scl = 1'b0; q_wait();
    m_sda = 1'b1;
    got_q.push_back(v);
  endtask

  // driver: queue the expected image, then read n bytes from register 0
  task automatic read_block(input int n, input string tag);
    logic ack;
    bus_start();
    send_byte(ADDR_R, ack);
    chk({tag, " R1 read address ack"}, {31'h0, ack}, 32'h1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(img[i]);
      tag_q.push_back($sformatf("%s R4 reg%0h", tag, i));
      recv_byte(i != n - 1);
    end
    chk({tag, " R4 released after NACK"}, {31'h0, sda_oe}, 32'h0);
    bus_stop();
    repeat (4) @(negedge clk);
  endtask

  task automatic write_bytes(input logic [7:0] d[], input string tag);
    logic ack;
    send_byte(ADDR_W, ack);
    chk({tag, " R1 write address ack"}, {31'h0, ack}, 32'h1);
    foreach (d[i]) begin
      send_byte(d[i], ack);
      chk({tag, " R3 data ack"}, {31'h0, ack}, 32'h1);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] wd[];
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2: strap capture visible on the outputs (mode low -> registers)
    chk("R2 lane_en", lane_en, 4'hF);
    chk("R2 lane_boost", lane_boost, 16'hAAAA);
    chk("R2 R7 lane_swing", lane_swing, 8'hFF);
    chk("R2 lane_deemph", lane_deemph, 8'h55);
    chk("R2 lane_det_pd", lane_det_pd, 4'hF);
    chk("R2 lane_rx_reset", lane_rx_reset, 4'h0);
    chk("R2 lane_thresh", lane_thresh, 8'h00);
    chk("R2 lane_act_dis", lane_act_dis, 4'h0);
    chk("R1 idle sda released", sda_oe, 1'b0);

    // R2 R5 R6: full register image after reset
    foreach (img[i]) img[i] = 8'h00;
    img[0] = 8'h50; img[2] = 8'hF0; img[3] = 8'hAA; img[4] = 8'hAA;
    img[5] = 8'hFF; img[6] = 8'h55; img[8] = 8'hF0;
    read_block(16, "R2 reset image");

    // R1: foreign address is not acknowledged and changes nothing
    bus_start();
    send_byte(BAD_W, ack);
    chk("R1 foreign address nack", ack, 1'b0);
    send_byte(8'h00, ack);
    chk("R1 foreign data nack", ack, 1'b0);
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R1 outputs untouched", lane_boost, 16'hAAAA);

    // R3 R5 R6 R7 R10: block write with leading offset byte
    wd = '{8'h00, 8'h55, 8'h5F, 8'h3C, 8'h96, 8'h00, 8'hE4, 8'hFF, 8'h0A, 8'hA7, 8'h1B, 8'hFF};
    bus_start();
    write_bytes(wd, "block write");
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R10 lane_en", lane_en, 4'b0101);
    chk("R10 lane_boost", lane_boost, 16'h963C);
    chk("R7 lane_swing low bits", lane_swing, 8'h55);
    chk("R10 lane_deemph", lane_deemph, 8'hE4);
    chk("R10 lane_thresh", lane_thresh, 8'h1B);
    chk("R10 lane_rx_reset", lane_rx_reset, 4'b1010);
    chk("R10 lane_det_pd", lane_det_pd, 4'b0000);
    chk("R10 lane_act_dis", lane_act_dis, 4'b1010);

    img[0] = 8'h50; img[1] = 8'h00; img[2] = 8'h50; img[3] = 8'h3C; img[4] = 8'h96;
    img[5] = 8'h55; img[6] = 8'hE4; img[7] = 8'h00; img[8] = 8'h0A; img[9] = 8'hA0;
    img[10] = 8'h1B; img[11] = 8'h00;
    read_block(12, "R5 R6 R7 readback");

    // R3: repeated START returns the pointer to register 0
    wd = '{8'h00, 8'h00, 8'hF0};
    bus_start();
    write_bytes(wd, "R3 pre-restart write");
    img[2] = 8'hF0;
    read_block(3, "R3 after repeated start");
    chk("R3 enable written", lane_en, 4'hF);

    // R5: status register follows the activity inputs
    activity_in = 4'b1010;
    repeat (4) @(negedge clk);
    img[0] = 8'hA0;
    read_block(1, "R5 activity");

    // R8 R9: mode pin selects the strap pins
    strap_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 boost from straps", lane_boost, 16'hAAAA);
    chk("R8 swing from straps", lane_swing, 8'hFF);
    chk("R8 deemph from straps", lane_deemph, 8'h55);
    chk("R9 thresh from regs", lane_thresh, 8'h1B);
    chk("R9 act_dis from regs", lane_act_dis, 4'b1010);
    boost_pins = 4'b0110;
    repeat (3) @(negedge clk);
    chk("R8 live strap change", lane_boost, 16'h6666);
    read_block(4, "R8 regs retained");
    strap_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 back to regs", lane_boost, 16'h963C);
    chk("R8 swing back to regs", lane_swing, 8'h55);

    repeat (20) @(negedge clk);
    if (exp_q.size() != 0) chk("R4 missing read bytes", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule